// File: doc/BRIEF.md
# Triple-port sequential field store

This block is a field memory for video streams. It has one serial input port and two serial output ports. All three ports run at the same time and do not depend on each other. The storage array is reached only in whole groups of 16 words of 12 bits. Every port has its own 16-word shift register and a 16-word transfer latch. A separate transfer command moves one group per clock cycle between a latch and the array.

On the input side, words stream into a shift register. A write strobe closes each block and copies the last 16 words into the input latch. A later write transfer stores that latch at a group address.

On the output side, a read transfer fills the latch of one output port. That port's start strobe then moves the latch into its shift register. The block streams out one word per valid/ready handshake. Each port has its own stream flow control, so the ports can run at different rates, as they would on separate serial clocks.

The input stream has no back-pressure. A word is taken on every cycle in which `in_valid` is high. An output port holds its word and its valid signal while its consumer keeps ready low. A port whose output enable is low goes quiet: valid is low, data is zero and nothing is consumed.

Top module: `tsam_top`

## Requirements
- R1: After reset, both output ports show valid low and data zero. All latches and shift registers are cleared, so a start issued before any read transfer delivers 16 zero words.
- R2: Each cycle with `in_valid` high shifts `in_data` into the input shift register. When `in_close` is high together with `in_valid`, the latest 16 words (this one included) are copied into the input latch, with the oldest at word position 0. `in_close` without `in_valid` has no effect.
- R3: A transfer with `xf_op` = 2 copies the input latch into the group at `xf_addr`. It copies the latch as it stood before the clock edge, so a block closed in the same cycle is not included.
- R4: A transfer with `xf_op` = 0 copies the addressed group into the latch of port A. `xf_op` = 1 copies it into the latch of port B. The other port's latch is not changed.
- R5: A start strobe loads the shift register from the port latch, using the latch value from before the edge. From the next cycle the port offers word positions 0 to 15 in order, one per handshake (valid and ready both high). After that, valid goes low.
- R6: While valid is high and ready is low, the offered word and valid stay unchanged in the next cycle, unless a start occurs.
- R7: A start during an unfinished block discards the rest of that block and begins again at word position 0 of the latch.
- R8: While a port's output enable is low, its valid is low and its data is zero, and no word is consumed. When the enable returns high, the port resumes at the same word.
- R9: A transfer whose address is not below N_GROUPS, or whose `xf_op` is 3, leaves the array and both output latches unchanged.
- R10: Input streaming, transfers and both output streams work in the same cycles without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xf_valid | input | 1 | Transfer command present this cycle |
| xf_op | input | 2 | 0 read to A, 1 read to B, 2 write from input latch, 3 no operation |
| xf_addr | input | ADDR_W | Group address |
| in_valid | input | 1 | Input word present |
| in_data | input | 12 | Input word |
| in_close | input | 1 | Closes the input block (qualified by in_valid) |
| a_start | input | 1 | Port A block start |
| a_oe | input | 1 | Port A output enable |
| a_ready | input | 1 | Port A consumer ready |
| a_valid | output | 1 | Port A word valid |
| a_data | output | 12 | Port A word |
| b_start | input | 1 | Port B block start |
| b_oe | input | 1 | Port B output enable |
| b_ready | input | 1 | Port B consumer ready |
| b_valid | output | 1 | Port B word valid |
| b_data | output | 12 | Port B word |

## Verification
Every group is first filled with a distinct ramp, so a read from the wrong group or a word delivered in the wrong order shows up as a wrong value. Directed blocks test several cases:
- a block closed in the same cycle as a write, which tells the pre-edge latch value apart from the post-edge one;
- a close strobe without an input word;
- out-of-range and no-operation transfers;
- back-pressure patterns, restarts in mid-block and enable toggling.

A long mixed run then drives all three ports and the transfer command together. Its stride patterns interleave reads, writes and starts, so any coupling between the ports breaks the comparison with the reference model on some cycle.

// File: rtl/tsam_pkg.sv
package tsam_pkg;
  localparam int WORD_W    = 12;
  localparam int GRP_WORDS = 16;
  localparam int GRP_BITS  = WORD_W * GRP_WORDS;
  localparam int CNT_W     = $clog2(GRP_WORDS + 1);

  typedef logic [WORD_W-1:0]   word_t;
  typedef logic [GRP_BITS-1:0] grp_t;

  typedef enum logic [1:0] {
    XF_RD_A = 2'd0,
    XF_RD_B = 2'd1,
    XF_WR_C = 2'd2,
    XF_NOP  = 2'd3
  } xf_op_e;
endpackage

// File: rtl/tsam_in_port.sv
module tsam_in_port
  import tsam_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  word_t in_data,
  input  logic  in_close,
  output grp_t  latch_q
);
  grp_t sreg_q;
  grp_t assembled;

  // newest word enters at the top; after 16 beats the oldest sits at position 0
  assign assembled = {in_data, sreg_q[GRP_BITS-1:WORD_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q  <= '0;
      latch_q <= '0;
    end else if (in_valid) begin
      sreg_q <= assembled;
      if (in_close) latch_q <= assembled;
    end
  end
endmodule

// File: rtl/tsam_array.sv
module tsam_array
  import tsam_pkg::*;
#(
  parameter int N_GROUPS = 48,
  parameter int ADDR_W   = 6
)(
  input  logic              clk,
  input  logic              xf_valid,
  input  logic [1:0]        xf_op,
  input  logic [ADDR_W-1:0] xf_addr,
  input  grp_t              wr_grp,
  output grp_t              rd_grp,
  output logic [1:0]        ld_en
);
  grp_t mem_q [N_GROUPS];
  logic in_range;
  logic [ADDR_W-1:0] idx;
  xf_op_e op;

  assign op       = xf_op_e'(xf_op);
  assign in_range = xf_valid && (int'(xf_addr) < N_GROUPS);
  assign idx      = in_range ? xf_addr : '0;
  assign rd_grp   = mem_q[idx];
  assign ld_en[0] = in_range && (op == XF_RD_A);
  assign ld_en[1] = in_range && (op == XF_RD_B);

  always_ff @(posedge clk) begin
    if (in_range && op == XF_WR_C) mem_q[idx] <= wr_grp;
  end
endmodule

// File: rtl/tsam_out_port.sv
module tsam_out_port
  import tsam_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_en,
  input  grp_t  load_grp,
  input  logic  start,
  input  logic  oe,
  input  logic  ready,
  output logic  valid,
  output word_t data
);
  grp_t latch_q;
  grp_t sreg_q;
  logic [CNT_W-1:0] left_q;

  assign valid = oe && (left_q != '0);
  assign data  = valid ? sreg_q[WORD_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      sreg_q  <= '0;
      left_q  <= '0;
    end else begin
      if (load_en) latch_q <= load_grp;
      if (start) begin
        sreg_q <= latch_q;
        left_q <= CNT_W'(GRP_WORDS);
      end else if (valid && ready) begin
        sreg_q <= {{WORD_W{1'b0}}, sreg_q[GRP_BITS-1:WORD_W]};
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsam_top.sv
module tsam_top
  import tsam_pkg::*;
#(
  parameter  int N_GROUPS = 48,
  localparam int ADDR_W   = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xf_valid,
  input  logic [1:0]        xf_op,
  input  logic [ADDR_W-1:0] xf_addr,
  input  logic              in_valid,
  input  logic [11:0]       in_data,
  input  logic              in_close,
  input  logic              a_start,
  input  logic              a_oe,
  input  logic              a_ready,
  output logic              a_valid,
  output logic [11:0]       a_data,
  input  logic              b_start,
  input  logic              b_oe,
  input  logic              b_ready,
  output logic              b_valid,
  output logic [11:0]       b_data
);
  grp_t in_latch;
  grp_t rd_grp;
  logic [1:0] ld_en;
  logic [1:0] st, en, rdy, vld;
  word_t dat [2];

  tsam_in_port u_in (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_close(in_close), .latch_q(in_latch)
  );

  tsam_array #(.N_GROUPS(N_GROUPS), .ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .xf_valid(xf_valid), .xf_op(xf_op), .xf_addr(xf_addr),
    .wr_grp(in_latch), .rd_grp(rd_grp), .ld_en(ld_en)
  );

  assign st  = {b_start, a_start};
  assign en  = {b_oe, a_oe};
  assign rdy = {b_ready, a_ready};

  for (genvar p = 0; p < 2; p++) begin : g_out
    tsam_out_port u_port (
      .clk(clk), .rst_n(rst_n), .load_en(ld_en[p]), .load_grp(rd_grp),
      .start(st[p]), .oe(en[p]), .ready(rdy[p]), .valid(vld[p]), .data(dat[p])
    );
  end

  assign a_valid = vld[0];
  assign a_data  = dat[0];
  assign b_valid = vld[1];
  assign b_data  = dat[1];
endmodule

// File: rtl/tsam_checks.sv
module tsam_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        a_start,
  input logic        a_oe,
  input logic        a_ready,
  input logic        a_valid,
  input logic [11:0] a_data,
  input logic        b_start,
  input logic        b_oe,
  input logic        b_ready,
  input logic        b_valid,
  input logic [11:0] b_data
);
  logic [4:0] a_hs, b_hs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_hs <= '0;
      b_hs <= '0;
    end else begin
      if (a_start) a_hs <= '0;
      else if (a_valid && a_ready) a_hs <= a_hs + 1'b1;
      if (b_start) b_hs <= '0;
      else if (b_valid && b_ready) b_hs <= b_hs + 1'b1;
    end
  end

  p_stall_hold_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && !a_ready && !a_start) |=> (!a_oe || (a_valid && $stable(a_data))));
  p_stall_hold_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready && !b_start) |=> (!b_oe || (b_valid && $stable(b_data))));
  p_quiet_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !a_oe |-> (!a_valid && a_data == 12'd0));
  p_quiet_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !b_oe |-> (!b_valid && b_data == 12'd0));
  p_start_offers_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    a_start |=> (!a_oe || a_valid));
  p_start_offers_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    b_start |=> (!b_oe || b_valid));
  p_block_len_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |-> (a_hs < 5'd16));
  p_block_len_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> (b_hs < 5'd16));
endmodule

bind tsam_top tsam_checks u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_start(a_start), .a_oe(a_oe), .a_ready(a_ready), .a_valid(a_valid), .a_data(a_data),
  .b_start(b_start), .b_oe(b_oe), .b_ready(b_ready), .b_valid(b_valid), .b_data(b_data)
);

// File: tb/tsam_top_bench.sv
module tsam_top_bench;
  localparam int CLK_P = 10;
  localparam int N = 48;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xf_valid = 1'b0;
  logic [1:0] xf_op = 2'd3;
  logic [AW-1:0] xf_addr = '0;
  logic in_valid = 1'b0, in_close = 1'b0;
  logic [11:0] in_data = '0;
  logic a_start = 1'b0, a_oe = 1'b1, a_ready = 1'b0;
  logic b_start = 1'b0, b_oe = 1'b1, b_ready = 1'b0;
  logic a_valid, b_valid;
  logic [11:0] a_data, b_data;

  int checks = 0, fails = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  logic [11:0] m_mem [N][16];
  logic [11:0] m_cl [16];
  logic [11:0] m_la [16];
  logic [11:0] m_lb [16];
  logic [11:0] cq [$];
  logic [11:0] asr [$];
  logic [11:0] bsr [$];

  always #(CLK_P/2) clk = ~clk;

  tsam_top #(.N_GROUPS(N)) u_tsam_top (
    .clk(clk), .rst_n(rst_n), .xf_valid(xf_valid), .xf_op(xf_op), .xf_addr(xf_addr),
    .in_valid(in_valid), .in_data(in_data), .in_close(in_close),
    .a_start(a_start), .a_oe(a_oe), .a_ready(a_ready), .a_valid(a_valid), .a_data(a_data),
    .b_start(b_start), .b_oe(b_oe), .b_ready(b_ready), .b_valid(b_valid), .b_data(b_data)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    cq.delete(); asr.delete(); bsr.delete();
    for (int i = 0; i < 16; i++) begin
      cq.push_back(12'd0); m_cl[i] = '0; m_la[i] = '0; m_lb[i] = '0;
    end
  endtask

  task automatic model_edge();
    logic [11:0] o_cl [16];
    logic [11:0] o_la [16];
    logic [11:0] o_lb [16];
    o_cl = m_cl; o_la = m_la; o_lb = m_lb;
    if (xf_valid && int'(xf_addr) < N) begin
      if (xf_op == 2'd0) for (int i = 0; i < 16; i++) m_la[i] = m_mem[xf_addr][i];
      else if (xf_op == 2'd1) for (int i = 0; i < 16; i++) m_lb[i] = m_mem[xf_addr][i];
      else if (xf_op == 2'd2) for (int i = 0; i < 16; i++) m_mem[xf_addr][i] = o_cl[i];
    end
    if (a_start) begin
      asr.delete();
      for (int i = 0; i < 16; i++) asr.push_back(o_la[i]);
    end else if (a_oe && asr.size() > 0 && a_ready) void'(asr.pop_front());
    if (b_start) begin
      bsr.delete();
      for (int i = 0; i < 16; i++) bsr.push_back(o_lb[i]);
    end else if (b_oe && bsr.size() > 0 && b_ready) void'(bsr.pop_front());
    if (in_valid) begin
      cq.push_back(in_data);
      void'(cq.pop_front());
      if (in_close) for (int i = 0; i < 16; i++) m_cl[i] = cq[i];
    end
  endtask

  task automatic compare();
    logic ev;
    ev = a_oe && asr.size() > 0;
    chk(cur_req, "a_valid", a_valid, ev);
    chk(cur_req, "a_data", a_data, ev ? asr[0] : 12'd0);
    ev = b_oe && bsr.size() > 0;
    chk(cur_req, "b_valid", b_valid, ev);
    chk(cur_req, "b_data", b_data, ev ? bsr[0] : 12'd0);
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_edge(); else model_reset();
    @(negedge clk);
    if (cmp_on) compare();
  endtask

  task automatic idle();
    xf_valid = 0; xf_op = 2'd3; in_valid = 0; in_close = 0; a_start = 0; b_start = 0;
  endtask

  task automatic xfer(logic [1:0] op, int addr);
    xf_valid = 1; xf_op = op; xf_addr = AW'(addr);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1;
    // R1: reset state, then a start delivers zero words
    chk("R1", "a_valid after reset", a_valid, 0);
    chk("R1", "b_valid after reset", b_valid, 0);
    chk("R1", "a_data after reset", a_data, 0);
    cmp_on = 1;
    cur_req = "R1";
    a_start = 1; tick(); a_start = 0; a_ready = 1;
    chk("R1", "zero block valid", a_valid, 1);
    chk("R1", "zero block word", a_data, 0);
    for (int i = 0; i < 18; i++) tick();

    // prefill every group with a ramp (R2, R3)
    cur_req = "R2 R3 prefill";
    for (int g = 0; g < N; g++) begin
      for (int i = 0; i < 16; i++) begin
        in_valid = 1; in_data = 12'(g * 16 + i); in_close = (i == 15); tick();
      end
      idle(); xfer(2'd2, g); tick(); idle();
    end

    // R3: write in the same cycle as the close uses the old latch
    cur_req = "R3";
    for (int i = 0; i < 16; i++) begin
      in_valid = 1; in_data = 12'hA00 + 12'(i); in_close = (i == 15);
      if (i == 15) xfer(2'd2, 5);
      tick(); idle();
    end
    xfer(2'd2, 6); tick(); idle();
    // R2: close without a valid word is ignored
    cur_req = "R2";
    in_close = 1; tick(); idle();
    xfer(2'd2, 7); tick(); idle();
    cur_req = "R4";
    xfer(2'd0, 6); tick();
    xfer(2'd1, 5); tick(); idle();
    a_start = 1; b_start = 1; a_ready = 1; b_ready = 1; tick(); idle();
    chk("R3", "new block first word", a_data, 12'hA00);
    chk("R3", "same-cycle write kept old latch", b_data, 12'(47 * 16));
    for (int i = 0; i < 17; i++) tick();
    xfer(2'd0, 7); tick(); idle();
    a_start = 1; tick(); idle();
    chk("R2", "stray close ignored", a_data, 12'hA00);
    for (int i = 0; i < 17; i++) tick();

    // R6: back-pressure pattern
    cur_req = "R6";
    xfer(2'd1, 9); tick(); idle();
    b_start = 1; tick(); b_start = 0;
    for (int i = 0; i < 40; i++) begin b_ready = (i % 3 == 2); tick(); end
    b_ready = 1;

    // R7: restart mid-block
    cur_req = "R7";
    xfer(2'd0, 12); tick(); idle();
    a_start = 1; tick(); a_start = 0;
    for (int i = 0; i < 5; i++) tick();
    a_start = 1; tick(); a_start = 0;
    chk("R7", "restart at word 0", a_data, 12'(12 * 16));
    for (int i = 0; i < 18; i++) tick();

    // R8: enable toggling
    cur_req = "R8";
    a_start = 1; tick(); a_start = 0;
    for (int i = 0; i < 40; i++) begin a_oe = (i % 6) < 3; tick(); end
    a_oe = 1;
    for (int i = 0; i < 18; i++) tick();

    // R9: out-of-range and no-op transfers
    cur_req = "R9";
    xfer(2'd0, 6); tick();
    xfer(2'd0, 50); tick();
    xfer(2'd2, 50); tick();
    xfer(2'd3, 3); tick(); idle();
    a_start = 1; tick(); idle();
    chk("R9", "latch unchanged", a_data, 12'hA00);
    for (int i = 0; i < 18; i++) tick();

    // R10: everything at once
    cur_req = "R10";
    begin
      int pushes = 0;
      for (int k = 0; k < 600; k++) begin
        idle();
        in_valid = (k % 5 != 4);
        in_data = 12'((k * 7) & 12'hfff);
        in_close = in_valid && (pushes % 16 == 15);
        if (in_valid) pushes++;
        case (k % 4)
          0: xfer(2'd0, (k * 3) % N);
          1: xfer(2'd1, (k * 5) % N);
          2: xfer(2'd2, (k / 4) % N);
          default: xfer(2'd3, k % 64);
        endcase
        a_start = (k % 23 == 0);
        b_start = (k % 19 == 3);
        a_ready = (k % 3 != 0);
        b_ready = (k % 2 == 0);
        a_oe = (k % 37) < 33;
        tick();
      end
    end
    idle(); a_oe = 1;
    for (int i = 0; i < 20; i++) tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule